// File: doc/BRIEF.md
# Sample-Stream Pulse-Width Modulator

This block drives one pulse-width modulated output whose duty values are taken from a short queue of samples. Software loads the queue through a small word-wide register port. A prescaled up-counter runs from zero to a programmable top value and wraps. During each period the active sample is compared with the counter, and the output is set or cleared at the wrap and at the compare point.

At every wrap a repeat counter advances. Once a sample has been used for its programmed number of periods, the next queued sample becomes active. If the queue is empty, the current sample stays in use. Sticky event flags, a live queue-low flag and a write-overflow flag feed one combined interrupt line through individual enables.

A soft-clear bit holds the datapath in its idle state. A clock-enable input gates the prescaler.

Top module: `sample_pwm`

## Requirements
- R1: While running, the counter steps from 0 up to the period value (register 4, bits 15:0). At the step taken from the period value it wraps to 0. The counter can be read at register 5. It stays frozen in any cycle where `clk_en` is low.
- R2: The counter steps once every (prescale+1) enabled cycles. The prescale value is held in control bits 27:16.
- R3: The output mode sits in control bits 3:2.
  - Mode 0 sets the output at the wrap and clears it at the step taken from the counter value equal to the sample.
  - Mode 1 does the opposite.
  - Modes 2 and 3 drive a constant 0.
  - When the wrap and the compare fall on the same step, the wrap wins.
- R4: The repeat field in control bits 5:4 selects 1, 2, 4 or 8 periods per sample for codes 0 to 3. When the count is used up at a wrap, the head of the queue becomes the active sample, which can be read at register 3.
- R5: When the queue is empty at such a wrap, the last active sample is kept.
- R6: Status bits 2:0 report the queue fill level, from 0 to 4.
- R7: A sample write (register 3) to a full queue is dropped and sets status bit 4. Writing 1 to that bit clears it.
- R8: Status bit 7 is high while the number of empty queue slots is at least the watermark value (control bits 7:6) plus one.
- R9: A wrap sets status bit 5 and a compare sets status bit 6. Both bits are sticky until a 1 is written to them.
- R10: `irq` is the OR of the wrap flag gated by enable bit 0, the compare flag gated by enable bit 1, and the queue-low flag gated by enable bit 2. The enables are in register 2.
- R11: Before the low 16 bits are queued, write data has its halves exchanged when control bit 8 is set, and its byte order then reversed when control bit 9 is set.
- R12: While control bit 1 (soft clear) is set, the counter, queue, active sample, repeat count, output and status flags are held at their reset values, and sample writes are ignored.
- R13: While control bit 0 (run) is low, the counter and output are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Enables prescaler advance |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Combined interrupt |

## Verification
The wrap event and the compare event coincide when the active sample equals the period value. The counter then leaves the period value on the same step that it wraps.

The bench provokes this by loading a sample equal to the period in both active modes. It judges the outcome by counting output-high cycles over one full period: every cycle in mode 0, none in mode 1. It also checks that both the wrap flag and the compare flag are set.

// File: rtl/spwm_pkg.sv
// Shared types for the sample-stream PWM.
// Assumes a 3-bit word-indexed register port.
package spwm_pkg;
    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_IEN  = 3'd2,
        A_SAMP = 3'd3,
        A_PER  = 3'd4,
        A_CNT  = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        OM_SET_FIRST = 2'd0,
        OM_CLR_FIRST = 2'd1,
        OM_OFF_A     = 2'd2,
        OM_OFF_B     = 2'd3
    } out_mode_e;
endpackage

// File: rtl/spwm_fifo.sv
// Small sample queue with one push port and one pop port, and a synchronous clear.
// Assumes push is never requested while full (the caller filters it) and pop is never requested while empty.
module spwm_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;

    // Storage write on push
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    assign head  = mem[rp];
    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);
endmodule

// File: rtl/spwm_timebase.sv
// Prescaler plus up-counter that wraps after the period value.
// step pulses when the counter advances; wrap pulses when that advance returns it to zero.
module spwm_timebase #(
    parameter int CW = 16,
    parameter int PRW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           run,
    input  logic           clk_en,
    input  logic [PRW-1:0] prescale,
    input  logic [CW-1:0]  period,
    output logic [CW-1:0]  cnt,
    output logic           step,
    output logic           wrap
);
    logic [PRW-1:0] pre;

    assign step = run && !clr && clk_en && (pre >= prescale);
    assign wrap = step && (cnt >= period);

    // Prescaler and counter advance
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            pre <= '0;
            cnt <= '0;
        end else if (clk_en) begin
            if (step) begin
                pre <= '0;
                cnt <= wrap ? '0 : cnt + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spwm_swap.sv
// Combinational reorder of a bus word.
// Optionally exchanges the halves, then optionally reverses the bytes, and returns the low OW bits.
module spwm_swap #(
    parameter int BW = 32,
    parameter int OW = 16,
    localparam int NB = BW / 8,
    localparam int HW = BW / 2
) (
    input  logic [BW-1:0] din,
    input  logic          half_x,
    input  logic          byte_r,
    output logic [OW-1:0] dout
);
    logic [BW-1:0] hs, rv, sel;

    assign hs = half_x ? {din[HW-1:0], din[BW-1:HW]} : din;

    for (genvar i = 0; i < NB; i++) begin : g_rev
        assign rv[i*8 +: 8] = hs[(NB-1-i)*8 +: 8];
    end

    assign sel  = byte_r ? rv : hs;
    assign dout = sel[OW-1:0];
endmodule

// File: rtl/sample_pwm.sv
// Sample-stream PWM top: register port, event flags, sample sequencing and output stage.
// Assumes a single clock. Register reads are combinational on bus_addr.
module sample_pwm
    import spwm_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    parameter int PRE_W = 12,
    parameter int BUS_W = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             pwm_out,
    output logic             irq
);
    logic             run_q, clr_q, hsw_q, brv_q;
    logic [1:0]       rep_q, wm_q;
    out_mode_e        mode_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] per_q, active_q, cnt, head, swapped;
    logic [2:0]       ien_q, rep_cnt, rep_lim;
    logic             roll_f, cmp_f, werr_f, low, out_q;
    logic             step, wrap, cmp_ev, push, pop, full, empty;
    logic [LVL_W-1:0] level;
    logic             wr_ctrl, wr_stat, wr_samp;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_samp = bus_wr && (bus_addr == A_SAMP);

    spwm_swap #(.BW(BUS_W), .OW(CNT_W)) swap_i (
        .din(bus_wdata), .half_x(hsw_q), .byte_r(brv_q), .dout(swapped));

    spwm_fifo #(.DEPTH(DEPTH), .DW(CNT_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_q), .push(push), .pop(pop),
        .din(swapped), .head(head), .level(level), .full(full), .empty(empty));

    spwm_timebase #(.CW(CNT_W), .PRW(PRE_W)) tb_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_q), .run(run_q), .clk_en(clk_en),
        .prescale(pre_q), .period(per_q), .cnt(cnt), .step(step), .wrap(wrap));

    assign push    = wr_samp && !clr_q && !full;
    assign rep_lim = 3'((4'd1 << rep_q) - 4'd1);
    assign pop     = wrap && (rep_cnt >= rep_lim) && !empty;
    assign cmp_ev  = step && (cnt == active_q);
    assign low     = (int'(DEPTH) - int'(level)) >= (int'(wm_q) + 1);

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0; clr_q <= 1'b0; hsw_q <= 1'b0; brv_q <= 1'b0;
            rep_q <= '0; wm_q <= '0; mode_q <= OM_SET_FIRST; pre_q <= '0;
            per_q <= '0; ien_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= bus_wdata[0];
                clr_q  <= bus_wdata[1];
                mode_q <= out_mode_e'(bus_wdata[3:2]);
                rep_q  <= bus_wdata[5:4];
                wm_q   <= bus_wdata[7:6];
                hsw_q  <= bus_wdata[8];
                brv_q  <= bus_wdata[9];
                pre_q  <= bus_wdata[16 +: PRE_W];
            end
            if (bus_wr && bus_addr == A_PER) per_q <= bus_wdata[CNT_W-1:0];
            if (bus_wr && bus_addr == A_IEN) ien_q <= bus_wdata[2:0];
        end
    end

    // Sticky event flags: a new event takes priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_q) begin
            roll_f <= 1'b0; cmp_f <= 1'b0; werr_f <= 1'b0;
        end else begin
            roll_f <= wrap   || (roll_f && !(wr_stat && bus_wdata[5]));
            cmp_f  <= cmp_ev || (cmp_f  && !(wr_stat && bus_wdata[6]));
            werr_f <= (wr_samp && full) || (werr_f && !(wr_stat && bus_wdata[4]));
        end
    end

    // Repeat counting and active-sample update at each wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clr_q) begin
            rep_cnt  <= '0;
            active_q <= '0;
        end else if (wrap) begin
            rep_cnt <= (rep_cnt >= rep_lim) ? '0 : rep_cnt + 1'b1;
            if (pop) active_q <= head;
        end
    end

    // Output state: a wrap outranks a compare on the same step
    always_ff @(posedge clk) begin
        if (!rst_n || clr_q || !run_q) out_q <= 1'b0;
        else if (wrap)                 out_q <= (mode_q == OM_SET_FIRST);
        else if (cmp_ev)               out_q <= (mode_q == OM_CLR_FIRST);
    end

    assign pwm_out = out_q && (mode_q == OM_SET_FIRST || mode_q == OM_CLR_FIRST);
    assign irq     = (roll_f && ien_q[0]) || (cmp_f && ien_q[1]) || (low && ien_q[2]);

    // Register read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[0] = run_q; bus_rdata[1] = clr_q; bus_rdata[3:2] = mode_q;
                bus_rdata[5:4] = rep_q; bus_rdata[7:6] = wm_q; bus_rdata[8] = hsw_q;
                bus_rdata[9] = brv_q; bus_rdata[16 +: PRE_W] = pre_q;
            end
            A_STAT: begin
                bus_rdata[LVL_W-1:0] = level; bus_rdata[4] = werr_f;
                bus_rdata[5] = roll_f; bus_rdata[6] = cmp_f; bus_rdata[7] = low;
            end
            A_IEN:   bus_rdata[2:0] = ien_q;
            A_SAMP:  bus_rdata[CNT_W-1:0] = active_q;
            A_PER:   bus_rdata[CNT_W-1:0] = per_q;
            A_CNT:   bus_rdata[CNT_W-1:0] = cnt;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sample_pwm_chk.sv
// Property checker for sample_pwm, attached by bind. It only observes.
module sample_pwm_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             run,
    input logic             wrap,
    input logic             samp_wr,
    input logic             full,
    input logic             pop,
    input logic [LVL_W-1:0] level,
    input logic [CNT_W-1:0] cnt,
    input logic             roll_f,
    input logic             werr_f,
    input logic             out_q
);
    assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);

    assert_wrap_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> roll_f);

    assert_full_write_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_wr && full && !clr) |=> werr_f);

    assert_full_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_wr && full && !clr && !pop) |=> level == LVL_W'(DEPTH));

    assert_soft_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && level == '0 && !out_q));

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0 && !out_q));
endmodule

bind sample_pwm sample_pwm_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_q), .run(run_q), .wrap(wrap),
    .samp_wr(wr_samp), .full(full), .pop(pop), .level(level), .cnt(cnt),
    .roll_f(roll_f), .werr_f(werr_f), .out_q(out_q));

// File: tb/sample_pwm_tb_top.sv
module sample_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    sample_pwm dut_i (.clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .irq(irq));

    always #5 clk = ~clk;

    typedef struct packed {
        logic [15:0] smp;
        logic [1:0]  mode;
        logic [7:0]  highs;
    } vec_t;

    // Period 5 gives six steps per period at prescale 0
    localparam vec_t VEC [0:8] = '{
        '{16'd0, 2'd0, 8'd1}, '{16'd2, 2'd0, 8'd3}, '{16'd5, 2'd0, 8'd6},
        '{16'd9, 2'd0, 8'd6}, '{16'd0, 2'd1, 8'd5}, '{16'd2, 2'd1, 8'd3},
        '{16'd5, 2'd1, 8'd0}, '{16'd3, 2'd2, 8'd0}, '{16'd3, 2'd3, 8'd0}};

    function automatic logic [31:0] mk_ctrl(input logic run, input logic clr,
            input logic [1:0] mode, input logic [1:0] rep, input logic [1:0] wm,
            input logic hs, input logic br, input logic [11:0] pre);
        return {4'b0, pre, 6'b0, br, hs, wm, rep, mode, clr, run};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, prev;
        int          hi, t, tmax;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(3'd1, d); check("R6 reset status", d, 32'h80);
        rd(3'd0, d); check("R12 reset control", d, 32'h0);
        rd(3'd5, d); check("R1 reset counter", d, 32'h0);
        check("R3 reset output", {31'b0, pwm_out}, 32'h0);
        check("R10 reset irq", {31'b0, irq}, 32'h0);

        // Output mode table
        foreach (VEC[vi]) begin
            wr(3'd0, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
            wr(3'd4, 32'd5);
            wr(3'd0, mk_ctrl(0, 0, VEC[vi].mode, 0, 0, 0, 0, 0));
            wr(3'd3, {16'h0, VEC[vi].smp});
            wr(3'd0, mk_ctrl(1, 0, VEC[vi].mode, 0, 0, 0, 0, 0));
            idle(20);
            hi = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                hi += int'(pwm_out);
            end
            check($sformatf("R3 vector %0d high cycles", vi), hi, VEC[vi].highs);
            if (VEC[vi].smp == 16'd5 && VEC[vi].mode == 2'd0) begin
                rd(3'd1, d); check("R9 wrap and compare flags together", d[6:5], 2'b11);
            end
        end

        // Disabled: counter and output held
        wr(3'd0, mk_ctrl(0, 1, 1, 0, 0, 0, 0, 0));
        wr(3'd0, mk_ctrl(0, 0, 1, 0, 0, 0, 0, 0));
        idle(10);
        rd(3'd5, d); check("R13 counter idle", d, 32'h0);
        check("R13 output idle", {31'b0, pwm_out}, 32'h0);

        // Queue overflow and write-one-to-clear
        for (int k = 0; k < 5; k++) wr(3'd3, 32'd100 + k);
        rd(3'd1, d); check("R7 overflow status", d, 32'h14);
        check("R6 full level", d[2:0], 3'd4);
        wr(3'd1, 32'h10);
        rd(3'd1, d); check("R7 overflow cleared", d, 32'h04);

        // Watermark
        wr(3'd0, mk_ctrl(0, 1, 0, 0, 1, 0, 0, 0));
        wr(3'd0, mk_ctrl(0, 0, 0, 0, 1, 0, 0, 0));
        wr(3'd3, 32'd1); wr(3'd3, 32'd2);
        rd(3'd1, d); check("R8 two empty, mark 1", d, 32'h82);
        wr(3'd0, mk_ctrl(0, 0, 0, 0, 2, 0, 0, 0));
        rd(3'd1, d); check("R8 two empty, mark 2", d, 32'h02);

        // Soft clear
        wr(3'd4, 32'd7);
        wr(3'd0, mk_ctrl(1, 0, 0, 0, 2, 0, 0, 0));
        idle(30);
        wr(3'd0, mk_ctrl(1, 1, 0, 0, 2, 0, 0, 0));
        wr(3'd3, 32'd9);
        idle(3);
        rd(3'd1, d); check("R12 status under clear", d, 32'h80);
        rd(3'd5, d); check("R12 counter under clear", d, 32'h0);
        rd(3'd3, d); check("R12 active sample under clear", d, 32'h0);

        // Write-data reordering
        for (int m = 0; m < 4; m++) begin
            logic [31:0] ex;
            ex = (m == 0) ? 32'h5678 : (m == 1) ? 32'h1234 : (m == 2) ? 32'h3412 : 32'h7856;
            wr(3'd0, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
            wr(3'd4, 32'd1);
            wr(3'd0, mk_ctrl(0, 0, 0, 0, 0, m[0], m[1], 0));
            wr(3'd3, 32'h1234_5678);
            wr(3'd0, mk_ctrl(1, 0, 0, 0, 0, m[0], m[1], 0));
            idle(10);
            rd(3'd3, d); check($sformatf("R11 reorder mode %0d", m), d, ex);
        end

        // Prescaler, counter range and clock enable
        wr(3'd0, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
        wr(3'd4, 32'd9);
        wr(3'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 12'd3));
        rd(3'd5, prev);
        do begin rd(3'd5, d); end while (d == prev);
        prev = d; t = 0;
        do begin rd(3'd5, d); t++; end while (d == prev);
        check("R2 cycles per step at prescale 3", t, 4);
        tmax = 0;
        for (int k = 0; k < 60; k++) begin
            rd(3'd5, d);
            if (int'(d) > tmax) tmax = int'(d);
        end
        check("R1 counter peak equals period", tmax, 9);
        clk_en = 1'b0;
        rd(3'd5, prev);
        idle(20);
        rd(3'd5, d); check("R1 frozen with clock enable low", d, prev);
        clk_en = 1'b1;

        // Repeat counts and hold on empty
        for (int r = 1; r < 4; r += 2) begin
            int t1;
            wr(3'd0, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
            wr(3'd4, 32'd3);
            wr(3'd0, mk_ctrl(0, 0, 0, r[1:0], 0, 0, 0, 0));
            wr(3'd3, 32'd10); wr(3'd3, 32'd20); wr(3'd3, 32'd30);
            wr(3'd0, mk_ctrl(1, 0, 0, r[1:0], 0, 0, 0, 0));
            t = 0;
            do begin rd(3'd3, d); t++; end while (d == 32'd0);
            t1 = t;
            do begin rd(3'd3, d); t++; end while (d == 32'd10);
            check($sformatf("R4 periods per sample, code %0d", r), t - t1, (r == 1) ? 8 : 32);
            idle(80);
            rd(3'd3, d); check("R5 last sample held", d, 32'd30);
            rd(3'd1, d); check("R6 drained level", d[2:0], 3'd0);
        end

        // Interrupt combining
        wr(3'd0, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
        wr(3'd4, 32'd2);
        wr(3'd2, 32'h1);
        wr(3'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0));
        idle(10);
        check("R10 wrap interrupt", {31'b0, irq}, 32'h1);
        wr(3'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 0, 0));
        wr(3'd1, 32'h60);
        rd(3'd1, d); check("R9 flags cleared", d[6:5], 2'b00);
        check("R10 irq after clear", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h4);
        check("R10 queue-low interrupt", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule